// File: doc/BRIEF.md
# Multiplexed Three-Digit Decade Counter

This block counts events on a slow count input with three chained decade stages (units, tens, hundreds) that all update on the same event, so the value runs 000 to 999 and wraps. The count input is brought into the system clock domain and its falling edges are detected there. A clock-disable input suppresses counting while it is high.

Each digit feeds a 4-bit snapshot latch. With latch enable low the snapshot follows the live count. With it high the snapshot is frozen while counting goes on. A small scan state machine shows the snapshot one digit at a time on a shared 4-bit BCD bus, with a one-hot digit strobe. The scan advances on a separate slow scan tick. An overflow pulse marks each wrap, so several blocks can be cascaded. The scan machine has three states: SCAN_UNITS, SCAN_TENS and SCAN_HUNDREDS. A scan tick takes SCAN_UNITS to SCAN_TENS, SCAN_TENS to SCAN_HUNDREDS, and SCAN_HUNDREDS back to SCAN_UNITS. Without a tick the state holds. Master reset forces SCAN_UNITS.

Top module: `bcd3_mux_counter`

## Requirements
- R1: The three decade stages form one synchronous counter that advances by exactly one per accepted count event, each digit in 0..9, wrapping from 999 to 000.
- R2: Only a falling edge of `count_in` is a count event. A rising edge has no effect. With two synchronizer flops, the new count is held in the counter after the third rising `clk` edge that follows the fall of `count_in`.
- R3: When `count_dis` is high in the cycle where a falling edge is detected, that edge is ignored and the count does not change.
- R4: While `latch_en` is low, the snapshot takes the live count on every clock. While `latch_en` is high, the snapshot holds even if the counter advances.
- R5: While `master_rst` is high, `bcd_out` is 0000. The reset also clears the counters and snapshots and returns the scan to the units digit.
- R6: `digit_sel` is always one-hot: bit 0 is units, bit 1 is tens and bit 2 is hundreds. `bcd_out` carries the snapshot of the selected digit.
- R7: Each cycle with `scan_tick` high moves the scan units→tens→hundreds→units. Without a tick, `digit_sel` holds.
- R8: `overflow` is high for exactly one clock, in the same cycle the counter wraps from 999 to 000, and is low at all other times.
- R9: Master reset takes priority over a simultaneous count event and over latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| master_rst | input | 1 | Synchronous active-high master reset |
| count_in | input | 1 | Asynchronous count input, counted on falling edges |
| count_dis | input | 1 | High: detected count edges are ignored |
| latch_en | input | 1 | High: hold snapshot; low: snapshot follows count |
| scan_tick | input | 1 | One-cycle pulse that advances the digit scan |
| bcd_out | output | 4 | BCD value of the selected digit |
| digit_sel | output | 3 | One-hot digit strobe (bit 0 = units) |
| overflow | output | 1 | One-cycle pulse on a 999→000 wrap |

## Verification
The bench targets the 9→0 carries across all digits and the full 999→000 wrap. A broken carry chain shows up as wrong tens or hundreds, and a missing or stretched pulse shows up as an overflow count other than one. It checks the exact cycle in which a counted edge reaches the bus, so an extra or missing synchronizer stage is exposed. It also checks that rising edges and disabled edges leave the value untouched. Random mixes of `latch_en`, `count_dis` and scan ticks would catch a snapshot that leaks while held, a scan that skips or repeats a digit, and a reset that leaves the bus or the scan position stale.

// File: rtl/bcd3_pkg.sv
package bcd3_pkg;
    localparam int DIGITS  = 3;
    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        SCAN_UNITS    = 2'd0,
        SCAN_TENS     = 2'd1,
        SCAN_HUNDREDS = 2'd2
    } scan_state_t;
endpackage

// File: rtl/bcd3_edge_sync.sv
module bcd3_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/bcd3_decade_chain.sv
module bcd3_decade_chain
    import bcd3_pkg::*;
#(
    parameter int N_DIG = DIGITS,
    parameter int DW    = DIGIT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [N_DIG*DW-1:0] count_o,
    output logic              wrap_o
);
    localparam logic [DW-1:0] TOP_VAL = DW'(9);

    logic [N_DIG:0] carry;
    assign carry[0] = step;

    for (genvar g = 0; g < N_DIG; g++) begin : g_dec
        logic [DW-1:0] cnt_q;
        logic          at_top;
        assign at_top       = (cnt_q == TOP_VAL);
        assign carry[g+1]   = carry[g] & at_top;
        assign count_o[g*DW +: DW] = cnt_q;

        always_ff @(posedge clk) begin
            if (rst)           cnt_q <= '0;
            else if (carry[g]) cnt_q <= at_top ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wrap_o <= 1'b0;
        else     wrap_o <= carry[N_DIG];
    end
endmodule

// File: rtl/bcd3_scan_fsm.sv
module bcd3_scan_fsm
    import bcd3_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    output logic [DIGITS-1:0] sel_o
);
    scan_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCAN_UNITS:    if (tick) state_d = SCAN_TENS;
            SCAN_TENS:     if (tick) state_d = SCAN_HUNDREDS;
            SCAN_HUNDREDS: if (tick) state_d = SCAN_UNITS;
            default:       state_d = SCAN_UNITS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SCAN_UNITS;
        else     state_q <= state_d;
    end

    always_comb begin
        sel_o = '0;
        unique case (state_q)
            SCAN_UNITS:    sel_o = 3'b001;
            SCAN_TENS:     sel_o = 3'b010;
            SCAN_HUNDREDS: sel_o = 3'b100;
            default:       sel_o = 3'b001;
        endcase
    end
endmodule

// File: rtl/bcd3_mux_counter.sv
module bcd3_mux_counter
    import bcd3_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               master_rst,
    input  logic               count_in,
    input  logic               count_dis,
    input  logic               latch_en,
    input  logic               scan_tick,
    output logic [DIGIT_W-1:0] bcd_out,
    output logic [DIGITS-1:0]  digit_sel,
    output logic               overflow
);
    localparam int TOT_W = DIGITS * DIGIT_W;

    logic             fall_det;
    logic             step;
    logic [TOT_W-1:0] count_q;
    logic [TOT_W-1:0] latch_q;

    bcd3_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst    (master_rst),
        .din    (count_in),
        .fall_o (fall_det)
    );

    assign step = fall_det & ~count_dis;

    bcd3_decade_chain #(.N_DIG(DIGITS), .DW(DIGIT_W)) i_chain (
        .clk     (clk),
        .rst     (master_rst),
        .step    (step),
        .count_o (count_q),
        .wrap_o  (overflow)
    );

    always_ff @(posedge clk) begin
        if (master_rst)    latch_q <= '0;
        else if (!latch_en) latch_q <= count_q;
    end

    bcd3_scan_fsm i_scan (
        .clk   (clk),
        .rst   (master_rst),
        .tick  (scan_tick),
        .sel_o (digit_sel)
    );

    always_comb begin
        bcd_out = '0;
        for (int i = 0; i < DIGITS; i++) begin
            if (digit_sel[i]) bcd_out = latch_q[i*DIGIT_W +: DIGIT_W];
        end
        if (master_rst) bcd_out = '0;
    end
endmodule

// File: rtl/bcd3_mux_counter_chk.sv
module bcd3_mux_counter_chk
    import bcd3_pkg::*;
(
    input logic                       clk,
    input logic                       master_rst,
    input logic                       count_dis,
    input logic                       latch_en,
    input logic                       scan_tick,
    input logic [DIGIT_W-1:0]         bcd_out,
    input logic [DIGITS-1:0]          digit_sel,
    input logic                       overflow,
    input logic [DIGITS*DIGIT_W-1:0]  count_q,
    input logic [DIGITS*DIGIT_W-1:0]  latch_q
);
    // R6
    sel_onehot_chk: assert property (@(posedge clk) disable iff (master_rst)
        $countones(digit_sel) == 1);

    // R8
    ovf_single_chk: assert property (@(posedge clk) disable iff (master_rst)
        overflow |=> !overflow);

    // R8
    ovf_zero_chk: assert property (@(posedge clk) disable iff (master_rst)
        overflow |-> count_q == '0);

    // R5
    rst_bus_chk: assert property (@(posedge clk)
        master_rst |-> bcd_out == '0);

    // R7
    scan_move_chk: assert property (@(posedge clk) disable iff (master_rst)
        scan_tick |=> digit_sel != $past(digit_sel));

    // R7
    scan_hold_chk: assert property (@(posedge clk) disable iff (master_rst)
        !scan_tick |=> $stable(digit_sel));

    // R3
    dis_hold_chk: assert property (@(posedge clk) disable iff (master_rst)
        count_dis |=> $stable(count_q));

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (master_rst)
        latch_en |=> $stable(latch_q));
endmodule

bind bcd3_mux_counter bcd3_mux_counter_chk i_chk (
    .clk        (clk),
    .master_rst (master_rst),
    .count_dis  (count_dis),
    .latch_en   (latch_en),
    .scan_tick  (scan_tick),
    .bcd_out    (bcd_out),
    .digit_sel  (digit_sel),
    .overflow   (overflow),
    .count_q    (count_q),
    .latch_q    (latch_q)
);

// File: tb/test_bcd3_mux_counter.sv
module test_bcd3_mux_counter;
    logic       clk = 1'b0;
    logic       master_rst = 1'b1;
    logic       count_in = 1'b1;
    logic       count_dis = 1'b0;
    logic       latch_en = 1'b0;
    logic       scan_tick = 1'b0;
    logic [3:0] bcd_out;
    logic [2:0] digit_sel;
    logic       overflow;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    int exp_lat = 0;
    int scan_idx = 0;
    int ovf_seen;
    bit done = 0;

    always #4 clk = ~clk;

    bcd3_mux_counter i_bcd3_mux_counter (
        .clk(clk), .master_rst(master_rst), .count_in(count_in),
        .count_dis(count_dis), .latch_en(latch_en), .scan_tick(scan_tick),
        .bcd_out(bcd_out), .digit_sel(digit_sel), .overflow(overflow)
    );

    function automatic int digit_of(int v, int i);
        int p = 1;
        for (int k = 0; k < i; k++) p = p * 10;
        return (v / p) % 10;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One count-input pulse: falls, held low 4 cycles, rises, settles 3.
    task automatic pulse();
        ovf_seen = 0;
        @(negedge clk) count_in = 1'b0;
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            if (overflow) ovf_seen++;
            if (k == 3) count_in = 1'b1;
        end
        if (!count_dis) begin
            exp_cnt = (exp_cnt + 1) % 1000;
        end
        if (!latch_en) exp_lat = exp_cnt;
    endtask

    task automatic tick();
        @(negedge clk) scan_tick = 1'b1;
        @(negedge clk) scan_tick = 1'b0;
        scan_idx = (scan_idx + 1) % 3;
    endtask

    // R6 R7: walk all three digits
    task automatic check_all();
        for (int j = 0; j < 3; j++) begin
            check("R6_sel", digit_sel, 1 << scan_idx);
            check("R6_bus", bcd_out, digit_of(exp_lat, scan_idx));
            tick();
        end
    endtask

    task automatic do_reset();
        @(negedge clk) master_rst = 1'b1;
        @(negedge clk);
        check("R5_bus", bcd_out, 0);
        check("R5_sel", digit_sel, 1);
        @(negedge clk) master_rst = 1'b0;
        exp_cnt = 0; exp_lat = 0; scan_idx = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R5_bus", bcd_out, 0);
        master_rst = 1'b0;
        @(negedge clk);
        check_all();

        // R2 latency: change reaches bus after 4th edge (3 sync/count + latch)
        @(negedge clk) count_in = 1'b0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        check("R2_early", bcd_out, 0);
        @(negedge clk);
        check("R2_late", bcd_out, 1);
        @(negedge clk) count_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R2_rise", bcd_out, 1);
        exp_cnt = 1; exp_lat = 1;

        // R3 disabled edge
        count_dis = 1'b1;
        pulse();
        count_dis = 1'b0;
        check_all();

        // R9 reset during a count event
        @(negedge clk) count_in = 1'b0;
        @(negedge clk); @(negedge clk) master_rst = 1'b1;
        @(negedge clk);
        check("R9_bus", bcd_out, 0);
        count_in = 1'b1;
        @(negedge clk) master_rst = 1'b0;
        repeat (3) @(negedge clk);
        exp_cnt = 0; exp_lat = 0; scan_idx = 0;
        check_all();

        // R1 R8 full sweep to wrap
        for (int n = 1; n <= 1000; n++) begin
            pulse();
            if (n < 1000) begin
                if (ovf_seen != 0) check("R8_quiet", ovf_seen, 0);
                if (n % 111 == 0) check_all();
            end else begin
                check("R8_pulse", ovf_seen, 1);
            end
        end
        check("R1_wrap", exp_cnt, 0);
        check_all();

        // R4 hold while counting
        latch_en = 1'b1;
        for (int n = 0; n < 12; n++) pulse();
        check_all();
        @(negedge clk) latch_en = 1'b0;
        @(negedge clk);
        exp_lat = exp_cnt;
        check_all();

        // random mix
        for (int it = 0; it < 300; it++) begin
            @(negedge clk);
            latch_en  = ($urandom % 4) == 0;
            count_dis = ($urandom % 4) == 0;
            @(negedge clk);
            if (!latch_en) exp_lat = exp_cnt;
            pulse();
            if (ovf_seen != 0) check("R8_rand", ovf_seen, 0);
            if (($urandom % 3) == 0) tick();
            if (it % 10 == 0) check_all();
        end
        count_dis = 1'b0;

        do_reset();
        check_all();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule